// File: doc/BRIEF.md
# Single-Register I2C Write Engine for a Power-Management Device

This block is a write-only I2C master that a voltage controller uses to update one register in an external power-management device. Software fills a packed command word with a 7-bit device address, an 8-bit register address and an 8-bit data byte. If the start flag in the same word is set, the engine runs one complete I2C write on an open-drain SCL/SDA pair. The start flag reads back as 1 until the transfer has finished, so software learns of completion by polling it.

The SCL high and low phase lengths are counts of system clocks. Each comes from a configuration register plus a fixed offset. A mode word holds a high-speed enable and a 2-bit master code. These are stored for software only; this engine always uses standard or fast signalling. If the device does not acknowledge a byte, the engine stops the transfer at once and raises a sticky error flag.

Top module: `pmic_wr_engine`

## Requirements
- R1: At bus address 0 the command word keeps the device address in bits 6:0, the register address in bits 15:8, the data byte in bits 23:16 and the start flag in bit 24. A read returns these fields, and all other bits (bit 7 among them) read as 0.
- R2: A write to address 0 with bit 24 set, made while no transfer is running, starts exactly one transfer. Bit 24 reads as 1 while the transfer runs and returns to 0 once the STOP condition has been sent.
- R3: A write to address 0 while bit 24 reads as 1 changes nothing: the fields and the flag keep their values and no further transfer follows.
- R4: At address 1, bits 7:0 hold the SCL-high count and bits 15:8 hold the SCL-low count, and both read back. Every SCL high phase lasts (high count + 5) system clocks and every SCL low phase lasts (low count + 7) system clocks.
- R5: At address 2, bit 3 (high-speed enable) and bits 1:0 (master code) read back and all other bits read 0. Their values have no effect on the signalling.
- R6: A transfer is sent in this order: START, the byte {device address, 0}, an ACK slot, the register byte, an ACK slot, the data byte, an ACK slot, STOP. Each byte is sent MSB first.
- R7: Inside a transfer, SDA changes while SCL is high only for START (a falling edge) and STOP (a rising edge).
- R8: When an ACK slot samples SDA high, the engine sends STOP straight after that slot and sends no later byte. It then sets the error flag and clears bit 24.
- R9: The error flag keeps its value through any other register writes. It is cleared only when the next transfer is accepted.
- R10: The SCL and SDA outputs are drive-low enables, as for open-drain lines. While idle and after reset, both lines are released. The engine samples SDA in the middle of each ACK-slot high phase.
- R11: A write to address 0 with bit 24 clear updates the fields and starts no bus activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the time base for the SCL phases |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 2 | Register select: 0 command, 1 clock config, 2 mode |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the register at reg_addr, combinational |
| sda_in | input | 1 | Level sensed on the SDA line |
| scl_drv_low | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_drv_low | output | 1 | 1 pulls SDA low, 0 releases it |
| err_flag | output | 1 | Sticky flag: a byte was not acknowledged |

## Verification
The hardest case to reach from the ports is a not-acknowledge in the middle of a transfer. Here the engine must abandon the byte order mid-frame, send a well-formed STOP and still clear the start flag. The bench gets there with a device model on the wired-AND SDA line that can withhold its ACK at a chosen byte index. The scoreboard queue holds only the bytes that should go out before the stop, so any extra byte or a missing STOP is reported. The ignored-write case is set up by writing a new command while polling shows the flag still set, then reading the fields back at once.

// File: rtl/pwe_pkg.sv
package pwe_pkg;
  localparam int CFG_W  = 8;
  localparam int HI_ADD = 5;
  localparam int LO_ADD = 7;
  localparam int PH_W   = CFG_W + 1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_BLO, ST_BHI, ST_PLO, ST_PHI
  } seq_st_t;

  // SCL high phase length in system clocks
  function automatic logic [PH_W-1:0] hi_len(input logic [CFG_W-1:0] c);
    return PH_W'(c) + PH_W'(HI_ADD);
  endfunction

  // SCL low phase length in system clocks
  function automatic logic [PH_W-1:0] lo_len(input logic [CFG_W-1:0] c);
    return PH_W'(c) + PH_W'(LO_ADD);
  endfunction

  // down-counter value reached around the middle of a phase of length len
  function automatic logic [PH_W-1:0] mid_tick(input logic [PH_W-1:0] len);
    return len >> 1;
  endfunction
endpackage

// File: rtl/pwe_phase_timer.sv
module pwe_phase_timer #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] len,
  output logic [W-1:0] count,
  output logic         expire
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             count <= '0;
    else if (load)          count <= len - W'(1);
    else if (count != '0)   count <= count - W'(1);
  end

  assign expire = (count == '0);
endmodule

// File: rtl/pwe_bit_seq.sv
module pwe_bit_seq
  import pwe_pkg::*;
#(
  parameter int CW = CFG_W,
  parameter int W  = PH_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [6:0]    dev,
  input  logic [7:0]    rega,
  input  logic [7:0]    dat,
  input  logic [CW-1:0] hi_cnt,
  input  logic [CW-1:0] lo_cnt,
  input  logic          sda_in,
  output logic          scl_low,
  output logic          sda_low,
  output logic          done,
  output logic          nack
);
  localparam logic [1:0] LAST_BYTE = 2'd2;
  localparam logic [3:0] ACK_POS   = 4'd8;

  seq_st_t      st, st_n;
  logic [3:0]   bit_idx;
  logic [1:0]   byte_idx;
  logic         sda_q, nack_q, fresh_q;
  logic         ld, tmr_exp;
  logic [W-1:0] ld_len, tmr_cnt, hlen, llen;
  logic [7:0]   cur_byte;
  logic         ack_slot, tx_bit, ack_sample;

  assign hlen       = hi_len(hi_cnt);
  assign llen       = lo_len(lo_cnt);
  assign ack_slot   = (bit_idx == ACK_POS);
  assign ack_sample = (st == ST_BHI) && ack_slot && (tmr_cnt == mid_tick(hlen));

  always_comb begin
    case (byte_idx)
      2'd0:    cur_byte = {dev, 1'b0};
      2'd1:    cur_byte = rega;
      default: cur_byte = dat;
    endcase
  end
  assign tx_bit = cur_byte[3'd7 - bit_idx[2:0]];

  pwe_phase_timer #(.W(W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(ld), .len(ld_len),
    .count(tmr_cnt), .expire(tmr_exp)
  );

  always_comb begin
    st_n = st; ld = 1'b0; ld_len = hlen;
    case (st)
      ST_IDLE:  if (start)   begin st_n = ST_START; ld = 1'b1; end
      ST_START: if (tmr_exp) begin st_n = ST_BLO; ld = 1'b1; ld_len = llen; end
      ST_BLO:   if (tmr_exp) begin st_n = ST_BHI; ld = 1'b1; end
      ST_BHI:   if (tmr_exp) begin
        ld = 1'b1; ld_len = llen;
        st_n = (ack_slot && (nack_q || byte_idx == LAST_BYTE)) ? ST_PLO : ST_BLO;
      end
      ST_PLO:   if (tmr_exp) begin st_n = ST_PHI; ld = 1'b1; end
      ST_PHI:   if (tmr_exp) st_n = ST_IDLE;
      default:  st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; bit_idx <= '0; byte_idx <= '0;
      sda_q <= 1'b1; nack_q <= 1'b0; fresh_q <= 1'b0;
    end else begin
      st      <= st_n;
      fresh_q <= ld;
      if (st == ST_IDLE && start) begin
        bit_idx <= '0; byte_idx <= '0; nack_q <= 1'b0; sda_q <= 1'b0;
      end
      if (st == ST_BLO && !fresh_q) sda_q <= ack_slot ? 1'b1 : tx_bit;
      if (st == ST_PLO && !fresh_q) sda_q <= 1'b0;
      if (st == ST_PHI && tmr_exp)  sda_q <= 1'b1;
      if (ack_sample)               nack_q <= sda_in;
      if (st == ST_BHI && tmr_exp) begin
        if (ack_slot) begin bit_idx <= '0; byte_idx <= byte_idx + 2'd1; end
        else          bit_idx <= bit_idx + 4'd1;
      end
    end
  end

  assign scl_low = (st == ST_BLO) || (st == ST_PLO);
  assign sda_low = !sda_q;
  assign done    = (st == ST_PHI) && tmr_exp;
  assign nack    = nack_q;

  // checker-side phase length measurement, independent of the timer
  seq_st_t      st_d;
  logic [W:0]   run_c, cyc_in;
  assign cyc_in = (st != st_d) ? (W+1)'(1) : run_c + (W+1)'(1);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin st_d <= ST_IDLE; run_c <= '0; end
    else        begin st_d <= st;      run_c <= cyc_in; end
  end

  a_r4_low_phase_len: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BLO && st_n != ST_BLO) |-> cyc_in == {1'b0, llen});
  a_r4_high_phase_len: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BHI && st_n != ST_BHI) |-> cyc_in == {1'b0, hlen});
  a_r7_sda_still_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BHI) |-> $stable(sda_q));
  a_r10_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> (!scl_low && !sda_low));
  a_r8_nack_ends_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BHI && tmr_exp && ack_slot && nack_q) |=> st == ST_PLO);
endmodule

// File: rtl/pwe_regs.sv
module pwe_regs #(
  parameter int AW = 2,
  parameter int DW = 32,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          seq_done,
  input  logic          seq_nack,
  output logic          start,
  output logic [6:0]    dev,
  output logic [7:0]    rega,
  output logic [7:0]    dat,
  output logic [CW-1:0] hi_cnt,
  output logic [CW-1:0] lo_cnt,
  output logic          err
);
  localparam logic [AW-1:0] A_CMD  = AW'(0);
  localparam logic [AW-1:0] A_CLK  = AW'(1);
  localparam logic [AW-1:0] A_MODE = AW'(2);
  localparam int GO_BIT = 24;
  localparam int HS_BIT = 3;

  logic       valid_q, hs_q;
  logic [1:0] mc_q;
  logic       cmd_wr;

  assign cmd_wr = wr_en && addr == A_CMD && !valid_q;
  assign start  = cmd_wr && wdata[GO_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dev <= '0; rega <= '0; dat <= '0; valid_q <= 1'b0; err <= 1'b0;
      hi_cnt <= '0; lo_cnt <= '0; hs_q <= 1'b0; mc_q <= '0;
    end else begin
      if (cmd_wr) begin
        dev     <= wdata[6:0];
        rega    <= wdata[15:8];
        dat     <= wdata[23:16];
        valid_q <= wdata[GO_BIT];
        if (wdata[GO_BIT]) err <= 1'b0;
      end
      if (seq_done) begin
        valid_q <= 1'b0;
        if (seq_nack) err <= 1'b1;
      end
      if (wr_en && addr == A_CLK) begin
        hi_cnt <= wdata[CW-1:0];
        lo_cnt <= wdata[2*CW-1:CW];
      end
      if (wr_en && addr == A_MODE) begin
        hs_q <= wdata[HS_BIT];
        mc_q <= wdata[1:0];
      end
    end
  end

  always_comb begin
    case (addr)
      A_CMD:   rdata = DW'({valid_q, dat, rega, 1'b0, dev});
      A_CLK:   rdata = DW'({lo_cnt, hi_cnt});
      A_MODE:  rdata = DW'({hs_q, 1'b0, mc_q});
      default: rdata = '0;
    endcase
  end

  logic unused_wbits;
  assign unused_wbits = ^{wdata[DW-1:GO_BIT+1], wdata[7]};

  a_r3_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_CMD && valid_q) |=> $stable({dev, rega, dat}));
  a_r2_flag_drops_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !valid_q);
  a_r8_err_from_nack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(seq_done && seq_nack));
  a_r9_err_clears_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err) |-> $past(start));
endmodule

// File: rtl/pmic_wr_engine.sv
module pmic_wr_engine
  import pwe_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr_en,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        sda_in,
  output logic        scl_drv_low,
  output logic        sda_drv_low,
  output logic        err_flag
);
  logic             start, done, nack;
  logic [6:0]       dev;
  logic [7:0]       rega, dat;
  logic [CFG_W-1:0] hi_cnt, lo_cnt;

  pwe_regs #(.AW(2), .DW(32), .CW(CFG_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .seq_done(done), .seq_nack(nack),
    .start(start), .dev(dev), .rega(rega), .dat(dat),
    .hi_cnt(hi_cnt), .lo_cnt(lo_cnt), .err(err_flag)
  );

  pwe_bit_seq #(.CW(CFG_W), .W(PH_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .dev(dev), .rega(rega),
    .dat(dat), .hi_cnt(hi_cnt), .lo_cnt(lo_cnt), .sda_in(sda_in),
    .scl_low(scl_drv_low), .sda_low(sda_drv_low), .done(done), .nack(nack)
  );
endmodule

// File: tb/test_pmic_wr_engine.sv
`timescale 1ns/1ps
module test_pmic_wr_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        scl_drv_low, sda_drv_low, err_flag;
  logic        slv_low = 1'b0;
  logic        scl_line, sda_line;

  always #2.5 clk = ~clk;

  assign scl_line = ~scl_drv_low;
  assign sda_line = ~(sda_drv_low | slv_low);

  pmic_wr_engine i_pmic_wr_engine (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sda_in(sda_line),
    .scl_drv_low(scl_drv_low), .sda_drv_low(sda_drv_low), .err_flag(err_flag)
  );

  int n_tot = 0, n_bad = 0;
  bit fin = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_tot++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard and device model state
  logic [7:0] exp_q[$];
  int  exp_h = 5, exp_l = 7;
  int  nack_at = -1;
  int  stops = 0, scl_low_seen = 0;
  bit  in_frame = 0, skip_first = 0, psc = 1, psd = 1;
  int  bits = 0, nbyte = 0, run = 0;
  logic [7:0] shreg = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      automatic bit sc = scl_line;
      automatic bit sd = sda_line;
      if (!sc) scl_low_seen++;
      if (sc && psc && psd && !sd && !in_frame) begin
        in_frame = 1; bits = 0; nbyte = 0; skip_first = 1;
      end else if (sc && psc && !psd && sd && in_frame) begin
        stops++;
        chk(bits == 1 && shreg[0] == 1'b0, "R6 stop after whole byte", bits, 1);
        in_frame = 0;
      end else if (sc && psc && sd != psd && in_frame) begin
        chk(0, "R7 sda moved while scl high", sd, psd);
      end
      if (in_frame && sc && !psc) begin
        chk(run == exp_l, "R4 scl low length", run, exp_l);
        if (bits < 8) begin shreg = {shreg[6:0], sd}; bits++; end
        else bits = 9;
      end
      if (in_frame && !sc && psc) begin
        if (skip_first) skip_first = 0;
        else chk(run == exp_h, "R4 scl high length", run, exp_h);
        if (bits == 8) begin
          if (exp_q.size() == 0) chk(0, "R6 unexpected byte", shreg, 0);
          else begin
            automatic logic [7:0] e = exp_q.pop_front();
            chk(shreg == e, "R6 byte content", shreg, e);
          end
          slv_low = (nbyte != nack_at);
        end else if (bits == 9) begin
          slv_low = 0; bits = 0; nbyte++;
        end
      end
      run = (sc == psc) ? run + 1 : 1;
      psc = sc; psd = sd;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wait_idle(output bit ok);
    logic [31:0] v;
    ok = 0;
    for (int i = 0; i < 5000; i++) begin
      rd(2'd0, v);
      if (!v[24]) begin ok = 1; break; end
      repeat (5) @(negedge clk);
    end
  endtask

  // driver: queue the bytes that must appear before STOP, then launch
  task automatic send(input logic [6:0] d, input logic [7:0] r, input logic [7:0] x,
                      input int nk, input string req);
    int s0;
    bit ok;
    logic [31:0] v;
    nack_at = nk;
    exp_q.push_back({d, 1'b0});
    if (nk != 0) exp_q.push_back(r);
    if (nk != 0 && nk != 1) exp_q.push_back(x);
    s0 = stops;
    wr(2'd0, {7'd0, 1'b1, x, r, 1'b0, d});
    rd(2'd0, v);
    chk(v[24] == 1'b1, {req, " flag set while busy"}, v[24], 1);
    wait_idle(ok);
    chk(ok, {req, " flag clears"}, ok, 1);
    repeat (3) @(negedge clk);
    chk(stops == s0 + 1, {req, " one stop"}, stops, s0 + 1);
    chk(exp_q.size() == 0, {req, " all bytes seen"}, exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_tot, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int s0, l0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(2'd0, v);
    chk(v == 0, "R1 reset command word", v, 0);
    chk(!err_flag, "R8 reset err", err_flag, 0);
    chk(!scl_drv_low && !sda_drv_low, "R10 lines released", {scl_drv_low, sda_drv_low}, 0);

    // R4 config readback: H = 3+5, L = 5+7
    wr(2'd1, 32'hFFFF_0503);
    rd(2'd1, v);
    chk(v == 32'h0000_0503, "R4 clock config readback", v, 32'h503);
    exp_h = 8; exp_l = 12;

    // R5 mode readback
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd2, v);
    chk(v == 32'h0000_000B, "R5 mode readback", v, 32'hB);

    // R1 / R11 field write without start
    s0 = stops; l0 = scl_low_seen;
    wr(2'd0, 32'hFEA5_C392 & 32'hFEFF_FFFF);
    rd(2'd0, v);
    chk(v == 32'h00A5_C312, "R1 fields readback", v, 32'h00A5C312);
    repeat (60) @(negedge clk);
    chk(scl_low_seen == l0 && stops == s0, "R11 no bus activity", scl_low_seen - l0, 0);

    // R2 / R6 full transfer; R3 write while busy
    nack_at = -1;
    exp_q.push_back(8'h24); exp_q.push_back(8'hC3); exp_q.push_back(8'hA5);
    s0 = stops;
    wr(2'd0, 32'h01A5_C312);
    repeat (20) @(negedge clk);
    wr(2'd0, 32'h01FF_FFFF);
    rd(2'd0, v);
    chk(v == 32'h01A5_C312, "R3 busy write ignored", v, 32'h01A5C312);
    begin
      bit ok;
      wait_idle(ok);
      chk(ok, "R2 flag clears", ok, 1);
    end
    repeat (3) @(negedge clk);
    chk(stops == s0 + 1, "R3 R2 single transfer", stops, s0 + 1);
    chk(exp_q.size() == 0, "R6 all bytes seen", exp_q.size(), 0);
    rd(2'd0, v);
    chk(v == 32'h00A5_C312, "R2 flag low fields kept", v, 32'h00A5C312);
    chk(!err_flag, "R8 no error on ack", err_flag, 0);

    // minimum timing with high-speed bit still set (R5 no effect)
    wr(2'd1, 32'h0000_0000);
    exp_h = 5; exp_l = 7;
    send(7'h7F, 8'h00, 8'hFF, -1, "R5 R6 edge pattern");
    chk(!err_flag, "R5 no error", err_flag, 0);

    // R8 nack on register byte
    wr(2'd1, 32'h0000_0A02);
    exp_h = 7; exp_l = 17;
    send(7'h2D, 8'h81, 8'h5A, 1, "R8 nack on second byte");
    chk(err_flag, "R8 err set", err_flag, 1);

    // R9 sticky through other writes, cleared by next start
    wr(2'd2, 32'h0);
    wr(2'd1, 32'h0000_0A02);
    chk(err_flag, "R9 err sticky", err_flag, 1);
    nack_at = -1;
    exp_q.push_back(8'h02); exp_q.push_back(8'h10); exp_q.push_back(8'h20);
    wr(2'd0, 32'h0120_1001);
    chk(!err_flag, "R9 err cleared on start", err_flag, 0);
    begin
      bit ok;
      wait_idle(ok);
      chk(ok, "R9 transfer completes", ok, 1);
    end
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R9 bytes seen", exp_q.size(), 0);

    // R8 nack on address byte
    send(7'h55, 8'h33, 8'hCC, 0, "R8 nack on address");
    chk(err_flag, "R8 err after address nack", err_flag, 1);
    chk(!scl_drv_low && !sda_drv_low, "R10 released after stop", {scl_drv_low, sda_drv_low}, 0);

    fin = 1'b1;
    $display("test done: total=%0d bad=%0d", n_tot, n_bad);
    $finish;
  end
endmodule